// File: doc/BRIEF.md
# Queued Multi-Target SPI Transfer Sequencer

This block is a transmit-only SPI master that drains a small queue of transfer descriptors with no processor involvement. Each descriptor selects one of several chip-select lines, gives an 8-bit clock divider and carries a 24-bit word. For each descriptor the block pulls the chosen chip select low and shifts the word out most significant bit first in SPI mode 0 at that descriptor's own clock rate. It then releases chip select and keeps it high for a programmable number of system clocks before starting the next frame.

Because the serial clock rate and the target line change from frame to frame, a fast converter and a slow oscillator controller can share one bus. A multi-channel converter update is simply several consecutive descriptors to the same target. A one-cycle pulse marks the end of every frame, and a status flag reports that the queue has drained and the bus is idle.

Top module: `burst_spi_seq`

## Requirements
- R1: After reset all chip-select lines are high, `sclk` is low, `xfer_done` is low, `queue_empty` is high and `push_ready` is high.
- R2: Each frame carries the descriptor word most significant bit first. `sclk` idles low, and `mosi` is stable while `sclk` is high, so a receiver samples it on the rising edge.
- R3: During a frame exactly one chip-select line is low: bit `push_sel` of `cs_n`, with line 0 as the least significant bit. Outside a frame all lines are high.
- R4: Each high phase and each low phase of `sclk` lasts `div+1` system clocks, so SCLK = clk / (2*(div+1)).
- R5: The divider is taken from each descriptor when its frame starts. Queued frames with different dividers each run at their own rate without any other action.
- R6: Between two frames the chip-select lines stay all high for at least `gap_cfg` system clocks, and for at least one clock when `gap_cfg` is 0.
- R7: `xfer_done` pulses high for exactly one clock per frame, in the same cycle that chip select returns high.
- R8: `queue_empty` is high only when no descriptor is queued and no frame is in progress. It rises in the same cycle as the `xfer_done` of the last queued frame.
- R9: Descriptors are sent in push order. A push while `push_ready` is low (queue full) is ignored and never appears on the bus.
- R10: Each frame has exactly 24 rising edges of `sclk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Offer a descriptor to the queue |
| push_sel | input | 2 | Target chip-select index |
| push_div | input | 8 | Clock divider for this frame |
| push_data | input | 24 | Word to transmit |
| push_ready | output | 1 | Queue has room; a push is accepted in this cycle |
| gap_cfg | input | 8 | Minimum chip-select high time in system clocks |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| cs_n | output | NUM_CS | Active-low chip selects, one per target |
| xfer_done | output | 1 | One-cycle pulse at the end of each frame |
| queue_empty | output | 1 | Queue drained and bus idle |

## Verification
Two functions can fall in the same clock. The first is a push into the queue in the cycle that the engine pops the head descriptor. The second is the end-of-frame pulse in the cycle the queue-empty flag rises or stays low. The bench queues several frames back to back while earlier ones are still being taken, so pushes and pops coincide. It then checks that every frame arrives intact and in order. At each frame end it records the flag alongside the pulse: the flag must be low while descriptors remain and high exactly at the last frame's pulse.

// File: rtl/spi_seq_pkg.sv
`timescale 1ns/1ps
package spi_seq_pkg;
    localparam int DATA_W  = 24;
    localparam int DIV_W   = 8;
    localparam int GAP_W   = 8;
    localparam int SEL_W   = 2;
    localparam int BITS_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } eng_state_t;

    typedef struct packed {
        eng_state_t          state;
        logic [SEL_W-1:0]    sel;
        logic [DIV_W-1:0]    div;
        logic [DIV_W-1:0]    cnt;
        logic [BITS_W-1:0]   bits;
        logic [DATA_W-1:0]   shreg;
        logic                sclk;
        logic [GAP_W-1:0]    gap;
        logic                done;
    } eng_regs_t;
endpackage

// File: rtl/spi_desc_fifo.sv
`timescale 1ns/1ps
module spi_desc_fifo #(
    parameter int WIDTH = 34,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr_d, wr_ptr_q, rd_ptr_d, rd_ptr_q;
    logic [AW:0]      count_d, count_q;
    logic             do_wr, do_rd;

    assign full    = (count_q == (AW+1)'(DEPTH));
    assign empty   = (count_q == '0);
    assign rd_data = mem[rd_ptr_q];

    always_comb begin
        do_wr    = wr_en && !full;
        do_rd    = rd_en && !empty;
        wr_ptr_d = do_wr ? wr_ptr_q + 1'b1 : wr_ptr_q;
        rd_ptr_d = do_rd ? rd_ptr_q + 1'b1 : rd_ptr_q;
        count_d  = count_q;
        if (do_wr && !do_rd)      count_d = count_q + 1'b1;
        else if (do_rd && !do_wr) count_d = count_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            wr_ptr_q <= wr_ptr_d;
            rd_ptr_q <= rd_ptr_d;
            count_q  <= count_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr_q] <= wr_data;
    end
endmodule

// File: rtl/spi_frame_engine.sv
`timescale 1ns/1ps
module spi_frame_engine
    import spi_seq_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    input  logic [SEL_W-1:0]  desc_sel,
    input  logic [DIV_W-1:0]  desc_div,
    input  logic [DATA_W-1:0] desc_data,
    output logic              desc_pop,
    input  logic [GAP_W-1:0]  gap_cfg,
    output logic              sclk,
    output logic              mosi,
    output logic [NUM_CS-1:0] cs_n,
    output logic              done,
    output logic              active
);
    localparam logic [BITS_W-1:0] LAST_BIT = BITS_W'(DATA_W - 1);

    eng_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        desc_pop = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (r_q.gap != '0) begin
                    r_d.gap = r_q.gap - 1'b1;
                end else if (desc_valid) begin
                    desc_pop  = 1'b1;
                    r_d.state = ST_SHIFT;
                    r_d.sel   = desc_sel;
                    r_d.div   = desc_div;
                    r_d.cnt   = desc_div;
                    r_d.shreg = desc_data;
                    r_d.bits  = '0;
                    r_d.sclk  = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else begin
                    r_d.cnt  = r_q.div;
                    r_d.sclk = !r_q.sclk;
                    if (r_q.sclk) begin
                        if (r_q.bits == LAST_BIT) begin
                            r_d.state = ST_TAIL;
                        end else begin
                            r_d.bits  = r_q.bits + 1'b1;
                            r_d.shreg = {r_q.shreg[DATA_W-2:0], 1'b0};
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.gap   = gap_cfg;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk   = r_q.sclk;
    assign mosi   = r_q.shreg[DATA_W-1];
    assign done   = r_q.done;
    assign active = (r_q.state != ST_IDLE);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = !(active && (r_q.sel == SEL_W'(i)));
    end
endmodule

// File: rtl/burst_spi_seq.sv
`timescale 1ns/1ps
module burst_spi_seq
    import spi_seq_pkg::*;
#(
    parameter int NUM_CS     = 4,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [SEL_W-1:0]  push_sel,
    input  logic [DIV_W-1:0]  push_div,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    input  logic [GAP_W-1:0]  gap_cfg,
    output logic              sclk,
    output logic              mosi,
    output logic [NUM_CS-1:0] cs_n,
    output logic              xfer_done,
    output logic              queue_empty
);
    localparam int DESC_W = SEL_W + DIV_W + DATA_W;

    logic [DESC_W-1:0] head;
    logic              fifo_full, fifo_empty, pop, active;

    spi_desc_fifo #(.WIDTH(DESC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_valid),
        .wr_data ({push_sel, push_div, push_data}),
        .full    (fifo_full),
        .rd_en   (pop),
        .rd_data (head),
        .empty   (fifo_empty)
    );

    spi_frame_engine #(.NUM_CS(NUM_CS)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_valid (!fifo_empty),
        .desc_sel   (head[DESC_W-1 -: SEL_W]),
        .desc_div   (head[DATA_W +: DIV_W]),
        .desc_data  (head[DATA_W-1:0]),
        .desc_pop   (pop),
        .gap_cfg    (gap_cfg),
        .sclk       (sclk),
        .mosi       (mosi),
        .cs_n       (cs_n),
        .done       (xfer_done),
        .active     (active)
    );

    assign push_ready  = !fifo_full;
    assign queue_empty = fifo_empty && !active;
endmodule

// File: rtl/spi_seq_checker.sv
`timescale 1ns/1ps
module spi_seq_checker #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              mosi,
    input logic [NUM_CS-1:0] cs_n,
    input logic              xfer_done,
    input logic              queue_empty,
    input logic              push_ready
);
    assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> !sclk);

    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_done_at_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> ((&cs_n) && !$past(&cs_n)));

    assert_empty_means_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        queue_empty |-> (&cs_n));

    assert_full_not_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !push_ready |-> !queue_empty);
endmodule

bind burst_spi_seq spi_seq_checker #(.NUM_CS(NUM_CS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk        (sclk),
    .mosi        (mosi),
    .cs_n        (cs_n),
    .xfer_done   (xfer_done),
    .queue_empty (queue_empty),
    .push_ready  (push_ready)
);

// File: tb/burst_spi_seq_tb.sv
`timescale 1ns/1ps
module burst_spi_seq_tb;
    localparam int NCS   = 4;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [1:0]  push_sel = '0;
    logic [7:0]  push_div = '0;
    logic [23:0] push_data = '0;
    logic        push_ready;
    logic [7:0]  gap_cfg = 8'd2;
    logic        sclk, mosi, xfer_done, queue_empty;
    logic [NCS-1:0] cs_n;

    always #10 clk = ~clk;

    burst_spi_seq #(.NUM_CS(NCS), .FIFO_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_sel(push_sel),
        .push_div(push_div), .push_data(push_data), .push_ready(push_ready),
        .gap_cfg(gap_cfg), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .xfer_done(xfer_done), .queue_empty(queue_empty)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // receiver model and frame log
    logic [23:0] f_data [64];
    int f_sel [64], f_bits [64], f_hmin [64], f_hmax [64], f_lmin [64], f_gap [64], f_qe [64];
    int fcnt = 0, done_err = 0, multi_err = 0;
    logic prev_low = 0, prev_sclk = 0;
    logic [23:0] sh;
    int bits, hrun, lrun, hmin, hmax, lmin, crun = 1000, cur_sel;

    always @(negedge clk) begin
        automatic logic low = ~&cs_n;
        if (rst_n) begin
            if ($countones(~cs_n) > 1) multi_err++;
            if (low && !prev_low) begin
                cur_sel = 0;
                for (int i = NCS-1; i >= 0; i--) if (!cs_n[i]) cur_sel = i;
                bits = 0; sh = '0; hrun = 0; lrun = 1; hmin = 999; hmax = 0; lmin = 999;
                if (fcnt < 64) f_gap[fcnt] = crun;
            end else if (low) begin
                if (sclk && !prev_sclk) begin
                    sh = {sh[22:0], mosi}; bits++; hrun = 1;
                    if (lrun < lmin) lmin = lrun;
                end else if (sclk) hrun++;
                else if (!sclk && prev_sclk) begin
                    if (hrun < hmin) hmin = hrun;
                    if (hrun > hmax) hmax = hrun;
                    lrun = 1;
                end else lrun++;
            end
            if (prev_low && !low) begin
                if (!xfer_done) done_err++;
                if (fcnt < 64) begin
                    f_data[fcnt] = sh; f_sel[fcnt] = cur_sel; f_bits[fcnt] = bits;
                    f_hmin[fcnt] = hmin; f_hmax[fcnt] = hmax; f_lmin[fcnt] = lmin;
                    f_qe[fcnt] = queue_empty;
                end
                fcnt++;
                crun = 1;
            end else begin
                if (xfer_done) done_err++;
                if (!low) crun++;
            end
            prev_low = low; prev_sclk = sclk;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_ge(string req, int act, int lim);
        n_chk++;
        if (act < lim) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
        end
    endtask

    task automatic push(input int sel, input int div, input logic [23:0] d);
        @(negedge clk);
        while (!push_ready) @(negedge clk);
        push_valid = 1'b1; push_sel = 2'(sel); push_div = 8'(div); push_data = d;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic wait_frames(input int target);
        while (fcnt < target) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cs_n", int'(cs_n), 4'hF);
        chk("R1 sclk", int'(sclk), 0);
        chk("R1 done", int'(xfer_done), 0);
        chk("R1 queue_empty", int'(queue_empty), 1);
        chk("R1 push_ready", int'(push_ready), 1);
    endtask

    task automatic t_single();
        int b = fcnt;
        push(1, 0, 24'hA5C3F1);
        @(negedge clk);
        chk("R8 busy not empty", int'(queue_empty), 0);
        wait_frames(b + 1);
        chk("R2 msb first data", int'(f_data[b]), 24'hA5C3F1);
        chk("R3 selected line", f_sel[b], 1);
        chk("R10 edge count", f_bits[b], 24);
        chk("R4 high phase div0", f_hmax[b], 1);
        chk("R4 low phase div0", f_lmin[b], 1);
        chk("R8 empty at last done", f_qe[b], 1);
        chk("R8 idle empty", int'(queue_empty), 1);
    endtask

    task automatic t_burst();
        int b = fcnt;
        logic [23:0] v [4] = '{24'h100001, 24'h2ABCDE, 24'h3FFFFF, 24'h400000};
        gap_cfg = 8'd2;
        for (int i = 0; i < 4; i++) push(2, 0, v[i]);
        wait_frames(b + 4);
        for (int i = 0; i < 4; i++) begin
            chk("R9 burst order", int'(f_data[b+i]), int'(v[i]));
            chk("R3 burst target", f_sel[b+i], 2);
            chk("R8 flag at done", f_qe[b+i], (i == 3) ? 1 : 0);
            if (i > 0) chk_ge("R6 gap 2", f_gap[b+i], 2);
        end
    endtask

    task automatic t_speeds();
        int b = fcnt;
        int dv [3] = '{0, 11, 3};
        for (int i = 0; i < 3; i++) push(i, dv[i], 24'h5A0000 + 24'(i));
        wait_frames(b + 3);
        for (int i = 0; i < 3; i++) begin
            chk("R5 high min", f_hmin[b+i], dv[i] + 1);
            chk("R5 high max", f_hmax[b+i], dv[i] + 1);
            chk("R4 low min", f_lmin[b+i], dv[i] + 1);
            chk("R2 data", int'(f_data[b+i]), int'(24'h5A0000 + 24'(i)));
            chk("R3 target", f_sel[b+i], i);
        end
    endtask

    task automatic t_gap();
        int b = fcnt;
        gap_cfg = 8'd6;
        push(3, 1, 24'h000111); push(3, 1, 24'h000222);
        wait_frames(b + 2);
        chk_ge("R6 gap 6", f_gap[b+1], 6);
        gap_cfg = 8'd0;
        b = fcnt;
        push(0, 0, 24'h777777); push(0, 0, 24'h888888);
        wait_frames(b + 2);
        chk_ge("R6 gap 0 still apart", f_gap[b+1], 1);
        chk("R6 second frame intact", int'(f_data[b+1]), 24'h888888);
        gap_cfg = 8'd2;
    endtask

    task automatic t_full();
        int b = fcnt, bad = 0;
        push(1, 40, 24'hC00000);
        for (int i = 0; i < DEPTH; i++) push(0, 0, 24'hC00001 + 24'(i));
        @(negedge clk);
        chk("R9 ready low when full", int'(push_ready), 0);
        push_valid = 1'b1; push_sel = 2'd0; push_div = 8'd0; push_data = 24'h0BAD00;
        @(negedge clk);
        push_valid = 1'b0;
        wait_frames(b + DEPTH + 1);
        repeat (200) @(negedge clk);
        chk("R9 frame count", fcnt - b, DEPTH + 1);
        for (int i = 0; i <= DEPTH; i++) begin
            if (f_data[b+i] == 24'h0BAD00) bad++;
            if (f_data[b+i] != 24'hC00000 + 24'(i)) bad++;
        end
        chk("R9 ignored push absent, order kept", bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_burst();
        t_speeds();
        t_gap();
        t_full();
        chk("R7 done pulses match releases", done_err, 0);
        chk("R3 never two lines low", multi_err, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule